// File: doc/BRIEF.md
# PCI Address Translation Unit

The block sits between a 32-bit PCI bus and a 32-bit local bus and works out, for each address presented to it, whether a transfer must cross from one side to the other and what the address becomes on the far side. Inbound addresses (from PCI) are claimed through a mask-and-compare against a base register and then remapped by keeping the bits the mask leaves free and filling in the rest from a translate value.

Outbound addresses (from the local side) are decoded against a fixed block of windows starting at 0x8000_0000. That block holds one 128 MB memory window per PCI bus, split into a single-address half and a dual-address half, and one 64 KB I/O window per bus. Below the windows there is a direct range that passes addresses through untouched when software enables it. A small register file, written one word per cycle, holds every base, mask, window value and control bit. Each lookup result appears one clock after the request.

Top module: `atu_xlate`

## Requirements
- R1: With `ib_valid` high, `ib_hit` is 1 in the following cycle exactly when (`ib_addr` AND inbound limit) equals inbound base; with `ib_valid` low, `ib_hit` is 0 in the following cycle.
- R2: On an inbound claim, `ib_laddr` in the following cycle is (`ib_addr` AND NOT limit) OR translate value; when the address is not claimed, `ib_laddr` is 0.
- R3: A valid outbound address in 0x8000_0000..0x83FF_FFFF (bus 0) or 0x8800_0000..0x8BFF_FFFF (bus 1) gives one cycle later `ob_req`=1, `ob_kind`=0 (memory), `ob_bus` set to that bus, `ob_addr_lo` = (address AND 0x03FF_FFFF) OR that bus's memory window value, and `ob_addr_hi`=0.
- R4: A valid outbound address in 0x8400_0000..0x87FF_FFFF (bus 0) or 0x8C00_0000..0x8FFF_FFFF (bus 1) gives `ob_kind`=1 (dual-address), the low word formed as in R3, and `ob_addr_hi` equal to that bus's upper-address register.
- R5: A valid outbound address in 0x9000_0000..0x9000_FFFF (bus 0) or 0x9001_0000..0x9001_FFFF (bus 1) gives `ob_kind`=2 (I/O), `ob_addr_lo` = (address AND 0x0000_FFFF) OR that bus's I/O window value, and `ob_addr_hi`=0.
- R6: With control bit 0 set, a valid outbound address in 0x0000_2000..0x7FFF_FFFF gives `ob_kind`=3 (direct), `ob_addr_lo` equal to the address, `ob_addr_hi`=0, and `ob_bus` equal to control bit 1.
- R7: A valid outbound address below 0x2000, above 0x9001_FFFF, or in the direct range while control bit 0 is clear, and any cycle with `ob_valid` low, give `ob_req`=0 with `ob_kind`, `ob_bus`, `ob_addr_lo` and `ob_addr_hi` all 0.
- R8: A write with `reg_we` high stores `reg_wdata` at index `reg_idx` (0 inbound base, 1 inbound limit, 2 translate value, 3/4 memory window value bus 0/1, 5/6 I/O window value bus 0/1, 7/8 upper-address bus 0/1, 9 control); it affects lookups from the next cycle on, not a lookup in the same cycle, and writes to indices 10..15 change nothing.
- R9: While `rst` is high every output is 0 in the following cycle, and all registers return to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| ib_valid | input | 1 | Inbound lookup request |
| ib_addr | input | 32 | Inbound PCI address |
| ib_hit | output | 1 | Inbound address claimed |
| ib_laddr | output | 32 | Translated local address |
| ob_valid | input | 1 | Outbound lookup request |
| ob_laddr | input | 32 | Outbound local address |
| ob_req | output | 1 | Outbound transfer required |
| ob_kind | output | 2 | Cycle type: 0 memory, 1 dual-address, 2 I/O, 3 direct |
| ob_bus | output | 1 | Target PCI bus |
| ob_addr_lo | output | 32 | PCI address, low word |
| ob_addr_hi | output | 32 | PCI address, high word (dual-address only) |

## Verification
The bench builds the block with its default sizes: two buses, 64 MB window halves and 64 KB I/O windows, so the window boundaries are the real ones. Because decoding is a comparison and not a table, both edges of every half, the last byte of the second I/O window and the first address past it, and the two ends of the direct range are all directly reachable. A register written in the same cycle as a lookup is included to pin down the ordering in R8.

// File: rtl/atu_pkg.sv
package atu_pkg;
  typedef enum logic [1:0] {
    OB_MEM    = 2'd0,
    OB_DAC    = 2'd1,
    OB_IO     = 2'd2,
    OB_DIRECT = 2'd3
  } ob_kind_e;
endpackage

// File: rtl/atu_regfile.sv
// Register storage: data words plus a narrow control word at the last index.
module atu_regfile #(
  parameter int AW     = 32,
  parameter int NDATA  = 9,
  parameter int CTRL_W = 2,
  parameter int IW     = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [IW-1:0]               idx,
  input  logic [AW-1:0]               wdata,
  output logic [NDATA-1:0][AW-1:0]    data_q,
  output logic [CTRL_W-1:0]           ctrl_q
);
  localparam int CTRL_IDX = NDATA;

  for (genvar g = 0; g < NDATA; g++) begin : g_data
    always_ff @(posedge clk) begin
      if (rst)                             data_q[g] <= '0;
      else if (we && idx == IW'(g))        data_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               ctrl_q <= '0;
    else if (we && idx == IW'(CTRL_IDX))   ctrl_q <= wdata[CTRL_W-1:0];
  end
endmodule

// File: rtl/atu_inbound.sv
// Mask-and-compare claim with remap, one registered stage.
module atu_inbound #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] xlate,
  output logic          hit_q,
  output logic [AW-1:0] laddr_q
);
  logic claim;
  assign claim = valid && ((addr & limit) == base);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      laddr_q <= '0;
    end else begin
      hit_q   <= claim;
      laddr_q <= claim ? ((addr & ~limit) | xlate) : '0;
    end
  end
endmodule

// File: rtl/atu_outbound.sv
// Outbound window decode and PCI address formation, one registered stage.
module atu_outbound
  import atu_pkg::*;
#(
  parameter int            AW        = 32,
  parameter int            NBUS      = 2,
  parameter int            HALF_BITS = 26,
  parameter int            IO_BITS   = 16,
  parameter logic [AW-1:0] WIN_BASE  = 'h8000_0000,
  parameter logic [AW-1:0] DIRECT_LO = 'h0000_2000,
  localparam int           BW        = (NBUS > 1) ? $clog2(NBUS) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid,
  input  logic [AW-1:0]            laddr,
  input  logic [NBUS-1:0][AW-1:0]  mem_val,
  input  logic [NBUS-1:0][AW-1:0]  io_val,
  input  logic [NBUS-1:0][AW-1:0]  up_val,
  input  logic                     dir_en,
  input  logic [BW-1:0]            dir_bus,
  output logic                     req_q,
  output ob_kind_e                 kind_q,
  output logic [BW-1:0]            bus_q,
  output logic [AW-1:0]            lo_q,
  output logic [AW-1:0]            hi_q
);
  localparam int            MEM_BITS = HALF_BITS + 1;
  localparam logic [AW-1:0] MEM_MASK = AW'((64'd1 << HALF_BITS) - 64'd1);
  localparam logic [AW-1:0] IO_MASK  = AW'((64'd1 << IO_BITS) - 64'd1);
  localparam logic [AW-1:0] IO_REGION = WIN_BASE + (AW'(NBUS) << MEM_BITS);

  logic [NBUS-1:0] mem_hit, io_hit;

  for (genvar g = 0; g < NBUS; g++) begin : g_win
    localparam logic [AW-1:0] MEM_B = WIN_BASE  + (AW'(g) << MEM_BITS);
    localparam logic [AW-1:0] IO_B  = IO_REGION + (AW'(g) << IO_BITS);
    assign mem_hit[g] = laddr[AW-1:MEM_BITS] == MEM_B[AW-1:MEM_BITS];
    assign io_hit[g]  = laddr[AW-1:IO_BITS]  == IO_B[AW-1:IO_BITS];
  end

  logic dir_hit;
  assign dir_hit = dir_en && (laddr >= DIRECT_LO) && (laddr < WIN_BASE);

  logic          req_d;
  ob_kind_e      kind_d;
  logic [BW-1:0] bus_d;
  logic [AW-1:0] lo_d, hi_d;

  always_comb begin
    req_d  = 1'b0;
    kind_d = OB_MEM;
    bus_d  = '0;
    lo_d   = '0;
    hi_d   = '0;
    if (valid) begin
      if (dir_hit) begin
        req_d  = 1'b1;
        kind_d = OB_DIRECT;
        bus_d  = dir_bus;
        lo_d   = laddr;
      end
      for (int b = 0; b < NBUS; b++) begin
        if (mem_hit[b]) begin
          req_d  = 1'b1;
          bus_d  = BW'(b);
          lo_d   = (laddr & MEM_MASK) | mem_val[b];
          if (laddr[HALF_BITS]) begin
            kind_d = OB_DAC;
            hi_d   = up_val[b];
          end else begin
            kind_d = OB_MEM;
          end
        end
        if (io_hit[b]) begin
          req_d  = 1'b1;
          kind_d = OB_IO;
          bus_d  = BW'(b);
          lo_d   = (laddr & IO_MASK) | io_val[b];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      kind_q <= OB_MEM;
      bus_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      req_q  <= req_d;
      kind_q <= kind_d;
      bus_q  <= bus_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end
endmodule

// File: rtl/atu_xlate.sv
module atu_xlate #(
  parameter int  AW        = 32,
  parameter int  NBUS      = 2,
  parameter int  HALF_BITS = 26,
  parameter int  IO_BITS   = 16,
  localparam int BW        = (NBUS > 1) ? $clog2(NBUS) : 1,
  localparam int NDATA     = 3 + 3 * NBUS,
  localparam int NREG      = NDATA + 1,
  localparam int IW        = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [IW-1:0] reg_idx,
  input  logic [AW-1:0] reg_wdata,
  input  logic          ib_valid,
  input  logic [AW-1:0] ib_addr,
  output logic          ib_hit,
  output logic [AW-1:0] ib_laddr,
  input  logic          ob_valid,
  input  logic [AW-1:0] ob_laddr,
  output logic          ob_req,
  output logic [1:0]    ob_kind,
  output logic [BW-1:0] ob_bus,
  output logic [AW-1:0] ob_addr_lo,
  output logic [AW-1:0] ob_addr_hi
);
  import atu_pkg::*;

  localparam int CTRL_W = 1 + BW;

  logic [NDATA-1:0][AW-1:0] data;
  logic [CTRL_W-1:0]        ctrl;
  logic [NBUS-1:0][AW-1:0]  mem_val, io_val, up_val;
  ob_kind_e                 kind;

  atu_regfile #(.AW(AW), .NDATA(NDATA), .CTRL_W(CTRL_W), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .idx(reg_idx), .wdata(reg_wdata),
    .data_q(data), .ctrl_q(ctrl)
  );

  for (genvar b = 0; b < NBUS; b++) begin : g_map
    assign mem_val[b] = data[3 + b];
    assign io_val[b]  = data[3 + NBUS + b];
    assign up_val[b]  = data[3 + 2 * NBUS + b];
  end

  atu_inbound #(.AW(AW)) u_in (
    .clk(clk), .rst(rst), .valid(ib_valid), .addr(ib_addr),
    .base(data[0]), .limit(data[1]), .xlate(data[2]),
    .hit_q(ib_hit), .laddr_q(ib_laddr)
  );

  atu_outbound #(.AW(AW), .NBUS(NBUS), .HALF_BITS(HALF_BITS), .IO_BITS(IO_BITS)) u_out (
    .clk(clk), .rst(rst), .valid(ob_valid), .laddr(ob_laddr),
    .mem_val(mem_val), .io_val(io_val), .up_val(up_val),
    .dir_en(ctrl[0]), .dir_bus(ctrl[CTRL_W-1:1]),
    .req_q(ob_req), .kind_q(kind), .bus_q(ob_bus),
    .lo_q(ob_addr_lo), .hi_q(ob_addr_hi)
  );

  assign ob_kind = kind;
endmodule

// File: rtl/atu_xlate_chk.sv
module atu_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ib_valid,
  input logic          ib_hit,
  input logic [AW-1:0] ib_laddr,
  input logic          ob_valid,
  input logic [AW-1:0] ob_laddr,
  input logic          ob_req,
  input logic [1:0]    ob_kind,
  input logic [AW-1:0] ob_addr_lo,
  input logic [AW-1:0] ob_addr_hi
);
  // R1: a claim only follows a valid inbound request
  a_r1_claim_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ib_hit |-> $past(ib_valid));

  // R2: unclaimed addresses leave the local address at zero
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !ib_hit |-> ib_laddr == '0);

  // R7: no request means quiet address outputs, and requests need a valid
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !ob_req |-> (ob_addr_lo == '0 && ob_addr_hi == '0 && ob_kind == 2'd0));
  a_r7_req_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ob_req |-> $past(ob_valid));

  // R4: only dual-address cycles carry an upper word
  a_r4_hi_only_dac: assert property (@(posedge clk) disable iff (rst)
    (ob_req && ob_kind != 2'd1) |-> ob_addr_hi == '0);

  // R5: I/O cycles keep the low 16 address bits
  a_r5_io_offset: assert property (@(posedge clk) disable iff (rst)
    (ob_req && ob_kind == 2'd2) |-> ob_addr_lo[15:0] == $past(ob_laddr[15:0]));

  // R6: direct cycles pass the address through unchanged
  a_r6_direct_pass: assert property (@(posedge clk) disable iff (rst)
    (ob_req && ob_kind == 2'd3) |-> ob_addr_lo == $past(ob_laddr));
endmodule

bind atu_xlate atu_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst),
  .ib_valid(ib_valid), .ib_hit(ib_hit), .ib_laddr(ib_laddr),
  .ob_valid(ob_valid), .ob_laddr(ob_laddr),
  .ob_req(ob_req), .ob_kind(ob_kind),
  .ob_addr_lo(ob_addr_lo), .ob_addr_hi(ob_addr_hi)
);

// File: tb/atu_xlate_bench.sv
module atu_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] reg_wdata = '0;
  logic        ib_valid = 1'b0;
  logic [31:0] ib_addr = '0;
  logic        ib_hit;
  logic [31:0] ib_laddr;
  logic        ob_valid = 1'b0;
  logic [31:0] ob_laddr = '0;
  logic        ob_req;
  logic [1:0]  ob_kind;
  logic        ob_bus;
  logic [31:0] ob_addr_lo, ob_addr_hi;

  always #10 clk = ~clk;  // 50 MHz

  atu_xlate u_atu_xlate (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .ib_valid(ib_valid), .ib_addr(ib_addr), .ib_hit(ib_hit), .ib_laddr(ib_laddr),
    .ob_valid(ob_valid), .ob_laddr(ob_laddr), .ob_req(ob_req), .ob_kind(ob_kind),
    .ob_bus(ob_bus), .ob_addr_lo(ob_addr_lo), .ob_addr_hi(ob_addr_hi)
  );

  int total = 0;
  int fails = 0;
  string ctx = "";
  logic [31:0] mreg [16];

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s (%s): actual %h expected %h", tag, what, ctx, act, exp);
    end
  endtask

  // One clock: drive at a falling edge, predict from the model's state before
  // this cycle's write, then compare at the next falling edge.
  task automatic cyc(input logic we, input logic [3:0] idx, input logic [31:0] wd,
                     input logic ibv, input logic [31:0] iba,
                     input logic obv, input logic [31:0] oba);
    logic e_hit; logic [31:0] e_la;
    logic e_req; logic [1:0] e_kind; logic e_bus; logic [31:0] e_lo, e_hi;
    string ti, to;
    reg_we = we; reg_idx = idx; reg_wdata = wd;
    ib_valid = ibv; ib_addr = iba; ob_valid = obv; ob_laddr = oba;
    e_hit = ibv && ((iba & mreg[1]) == mreg[0]);
    e_la  = e_hit ? ((iba & ~mreg[1]) | mreg[2]) : 32'h0;
    ti = e_hit ? "R2" : "R1";
    e_req = 0; e_kind = 0; e_bus = 0; e_lo = 0; e_hi = 0; to = "R7";
    if (obv) begin
      if (oba >= 32'h2000 && oba <= 32'h7FFF_FFFF && mreg[9][0]) begin
        e_req = 1; e_kind = 3; e_bus = mreg[9][1]; e_lo = oba; to = "R6";
      end else if (oba >= 32'h8000_0000 && oba <= 32'h8FFF_FFFF) begin
        int b;
        b = (oba >= 32'h8800_0000) ? 1 : 0;
        e_req = 1; e_bus = b[0];
        e_lo = (oba & 32'h03FF_FFFF) | mreg[3 + b];
        if ((b == 0 && oba >= 32'h8400_0000) || (b == 1 && oba >= 32'h8C00_0000)) begin
          e_kind = 1; e_hi = mreg[7 + b]; to = "R4";
        end else begin
          e_kind = 0; to = "R3";
        end
      end else if (oba >= 32'h9000_0000 && oba <= 32'h9001_FFFF) begin
        int b;
        b = (oba >= 32'h9001_0000) ? 1 : 0;
        e_req = 1; e_kind = 2; e_bus = b[0];
        e_lo = (oba & 32'h0000_FFFF) | mreg[5 + b]; to = "R5";
      end
    end
    if (we && idx <= 4'd9) mreg[idx] = (idx == 4'd9) ? (wd & 32'h3) : wd;
    @(negedge clk);
    if (ibv || ib_hit) begin
      check(ti, "ib_hit", 64'(ib_hit), 64'(e_hit));
      check(ti, "ib_laddr", 64'(ib_laddr), 64'(e_la));
    end
    if (obv) begin
      check(to, "ob_req", 64'(ob_req), 64'(e_req));
      check(to, "ob_kind", 64'(ob_kind), 64'(e_kind));
      check(to, "ob_bus", 64'(ob_bus), 64'(e_bus));
      check(to, "ob_addr", {ob_addr_hi, ob_addr_lo}, {e_hi, e_lo});
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] wd);
    cyc(1'b1, idx, wd, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic ob(input logic [31:0] a);
    cyc(1'b0, 4'd0, 32'h0, 1'b0, 32'h0, 1'b1, a);
  endtask

  task automatic ib(input logic v, input logic [31:0] a);
    cyc(1'b0, 4'd0, 32'h0, v, a, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
    ctx = "reset";
    rst = 1'b1; ib_valid = 1'b1; ob_valid = 1'b1; ob_laddr = 32'h8000_0000;
    repeat (3) @(negedge clk);
    // R9: outputs held at zero during reset even with requests present
    check("R9", "ib_hit", 64'(ib_hit), 64'h0);
    check("R9", "ob_req", 64'(ob_req), 64'h0);
    check("R9", "ob_addr", {ob_addr_hi, ob_addr_lo}, 64'h0);
    rst = 1'b0;
    // R9: registers are zero after reset, so base 0 / limit 0 claims everything
    ctx = "post-reset registers";
    ib(1'b1, 32'hDEAD_BEEF);
    ob(32'h8400_0000);

    ctx = "inbound";
    wr(4'd0, 32'h4000_0000); wr(4'd1, 32'hF000_0000); wr(4'd2, 32'h0010_0000);
    ib(1'b1, 32'h4123_4567);   // R2 claim and remap
    ib(1'b1, 32'h5000_0000);   // R1 miss
    ib(1'b0, 32'h4000_0000);   // R1 no request
    ib(1'b1, 32'h4FFF_FFFF);

    ctx = "outbound windows";
    wr(4'd3, 32'hC000_0000); wr(4'd4, 32'hD000_0000);
    wr(4'd5, 32'h0001_0000); wr(4'd6, 32'h0002_0000);
    wr(4'd7, 32'h0000_0001); wr(4'd8, 32'h0000_0002);
    ob(32'h8000_0000); ob(32'h83FF_FFFF);           // R3 bus 0
    ob(32'h8400_0010); ob(32'h87FF_FFFF);           // R4 bus 0
    ob(32'h8800_1234); ob(32'h8BFF_FFFF);           // R3 bus 1
    ob(32'h8C00_0000); ob(32'h8FFF_FFFF);           // R4 bus 1
    ob(32'h9000_ABCD); ob(32'h9001_0000); ob(32'h9001_FFFF); // R5
    ob(32'h9002_0000); ob(32'hFFFF_FFFF); ob(32'h1FFF);      // R7
    ob(32'h2000); ob(32'h7FFF_FFFF);                // R7 direct disabled

    ctx = "direct";
    wr(4'd9, 32'h1);
    ob(32'h2000); ob(32'h7FFF_FFFF); ob(32'h1FFF);  // R6 edges, R7 below
    wr(4'd9, 32'h3);
    ob(32'h1234_5678);                              // R6 bus select
    ob(32'h8000_0004);

    ctx = "R8 ordering";
    // write and lookup in the same cycle: lookup sees the old value
    cyc(1'b1, 4'd3, 32'hA000_0000, 1'b0, 32'h0, 1'b1, 32'h8000_0008);
    ob(32'h8000_0008);
    cyc(1'b1, 4'd1, 32'h0000_0000, 1'b1, 32'h4000_0000, 1'b0, 32'h0);
    ib(1'b1, 32'h4000_0000);

    ctx = "R8 bad index";
    wr(4'd10, 32'hFFFF_FFFF); wr(4'd15, 32'h5555_5555);
    ob(32'h8400_0000); ob(32'h8C00_0000); ob(32'h9001_0001); ob(32'h3000_0000);
    ib(1'b1, 32'h4000_0000);

    ctx = "reset again";
    rst = 1'b1; ob_valid = 1'b0; ib_valid = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
    ob(32'h4000_0000);                              // R9 control cleared
    ob(32'h8400_0000);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule